// File: doc/BRIEF.md
# Host-to-local address window remapper

This block sits between a host firmware-space request stream and a local bus. Each host request carries a 32-bit address. The block decides whether that address falls inside a single programmable window. If it does, and the window is enabled, the block sends out a translated local address. The window granularity is 64 KiB, so only address bits 31:16 take part in matching and translation. Bits 15:0 pass straight through.

Software programs three registers through a simple write strobe with combinational readback:

- The control register carries two enable bits. Both must be set before anything is forwarded.
- The remap register holds two base fields. Its lower half is the host-side base and its upper half is the local base.
- The mask register holds two halves. The lower half marks the host address bits that pass through untouched as window offset. The upper half marks the bits that are replaced by the local base.

For a power-of-two window of size S placed at a multiple of S, software writes the mask as the bitwise inverse of (S-1) ORed with ((S>>16)-1).

Every host request gets exactly one response, one clock later. The response carries a hit flag and either the translated address or zero.

Top module: `host_window_remap`

## Requirements
- R1: After reset the enables, the remap register and the mask register are all zero. No response is valid, and every register reads back zero.
- R2: The register offsets and their readback are as follows.
  - Offset 0x0 is the control register. Only bits 8 and 10 are stored, and all other bits read as zero.
  - Offset 0x8 is the remap register, and offset 0xc is the mask register. Both store and read back all 32 bits.
- R3: Any other register offset reads zero, and a write to it changes no register.
- R4: A request is forwarded only when control bits 8 and 10 are both set. With either bit clear, the response has the hit flag low.
- R5: The hit test compares host address bits 31:16 with remap bits 15:0. The request hits when they are equal in every position where mask bit (position-16) is 0. Positions whose lower mask bit is 1 are not compared.
- R6: On a hit, each local address bit k (for k from 16 to 31) takes remap bit k when mask bit k is 1, and host bit k otherwise. Local address bits 15:0 equal host address bits 15:0.
- R7: On a miss, or when the window is disabled, the response is valid with the hit flag low and the local address zero.
- R8: A response is valid exactly one clock after a cycle with the host request valid. Otherwise the output valid, the hit flag and the address are all low.
- R9: A register write is used by requests sampled on later edges. A request sampled on the same edge as the write uses the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| host_valid | input | 1 | Host request valid |
| host_addr | input | 32 | Host firmware-space address |
| out_valid | output | 1 | Response valid |
| out_hit | output | 1 | Request hit an enabled window |
| out_addr | output | 32 | Translated local address, zero on a miss |

## Verification
The hardest case to reach from the ports is a register write on the same edge as a request. In that case the response must reflect the old remap or mask contents, while the very next request sees the new ones. The stimulus overlaps writes with requests often, including back-to-back requests across a reconfiguration.

Arbitrary, non-contiguous mask patterns are also hard to reach through well-formed window setups. The bench therefore mixes aligned power-of-two windows with fully random mask and remap words. It aims addresses both inside and just outside the window so that every compare and replace bit is exercised.

// File: rtl/host_window_remap.sv
module host_window_remap #(
  parameter int AW        = 32,
  parameter int RA_W      = 4,
  parameter int OFS_CTRL  = 0,
  parameter int OFS_REMAP = 8,
  parameter int OFS_MASK  = 12,
  parameter int EN_A_BIT  = 8,
  parameter int EN_B_BIT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          host_valid,
  input  logic [AW-1:0] host_addr,
  output logic          out_valid,
  output logic          out_hit,
  output logic [AW-1:0] out_addr
);
  localparam int HW = AW / 2;

  logic          en_a, en_b;
  logic [AW-1:0] remap_q, mask_q;

  wire sel_ctrl  = reg_addr == RA_W'(OFS_CTRL);
  wire sel_remap = reg_addr == RA_W'(OFS_REMAP);
  wire sel_mask  = reg_addr == RA_W'(OFS_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a    <= 1'b0;
      en_b    <= 1'b0;
      remap_q <= '0;
      mask_q  <= '0;
    end else if (reg_wr) begin
      if (sel_ctrl) begin
        en_a <= reg_wdata[EN_A_BIT];
        en_b <= reg_wdata[EN_B_BIT];
      end
      if (sel_remap) remap_q <= reg_wdata;
      if (sel_mask)  mask_q  <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata[EN_A_BIT] = en_a;
      reg_rdata[EN_B_BIT] = en_b;
    end else if (sel_remap) begin
      reg_rdata = remap_q;
    end else if (sel_mask) begin
      reg_rdata = mask_q;
    end
  end

  wire [HW-1:0] req_hi   = host_addr[AW-1:HW];
  wire          in_win   = ((req_hi ^ remap_q[HW-1:0]) & ~mask_q[HW-1:0]) == '0;
  wire [HW-1:0] local_hi = (remap_q[AW-1:HW] & mask_q[AW-1:HW]) | (req_hi & ~mask_q[AW-1:HW]);
  wire          fwd      = host_valid & en_a & en_b & in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= host_valid;
      out_hit   <= fwd;
      out_addr  <= fwd ? {local_hi, host_addr[HW-1:0]} : '0;
    end
  end

  a_r4_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> $past(en_a && en_b));

  a_r6_low_half_passes: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_addr[HW-1:0] == $past(host_addr[HW-1:0]));

  a_r7_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> out_addr == '0);

  a_r8_hit_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);

  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_ctrl || sel_remap || sel_mask) |-> reg_rdata == '0);
endmodule

// File: tb/test_host_window_remap.sv
module test_host_window_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_valid = 1'b0;
  logic [31:0] host_addr = '0;
  logic        out_valid, out_hit;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_window_remap i_host_window_remap (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_valid(host_valid),
    .host_addr(host_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_addr(out_addr)
  );

  // behavioural reference
  bit          m_en_a, m_en_b;
  logic [31:0] m_remap, m_mask;
  logic        e_valid, e_hit;
  logic [31:0] e_addr;
  string       e_tag = "R1";

  always @(posedge clk) begin
    bit inwin;
    if (!rst_n) begin
      m_en_a = 0; m_en_b = 0; m_remap = 0; m_mask = 0;
      e_valid = 0; e_hit = 0; e_addr = 0; e_tag = "R1";
    end else begin
      e_valid = host_valid; e_hit = 0; e_addr = 0; e_tag = "R8";
      if (host_valid) begin
        inwin = 1;
        for (int b = 0; b < 16; b++)
          if (!m_mask[b] && host_addr[16+b] !== m_remap[b]) inwin = 0;
        if (!(m_en_a && m_en_b)) e_tag = "R4";
        else if (!inwin) e_tag = "R5";
        else begin
          e_hit = 1; e_tag = "R6";
          e_addr[15:0] = host_addr[15:0];
          for (int b = 16; b < 32; b++)
            e_addr[b] = m_mask[b] ? m_remap[b] : host_addr[b];
        end
        if (reg_wr) e_tag = "R9";
      end
      if (reg_wr) begin
        case (reg_addr)
          4'h0: begin m_en_a = reg_wdata[8]; m_en_b = reg_wdata[10]; end
          4'h8: m_remap = reg_wdata;
          4'hc: m_mask  = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_read(logic [3:0] a);
    logic [31:0] v = 0;
    case (a)
      4'h0: begin v[8] = m_en_a; v[10] = m_en_b; end
      4'h8: v = m_remap;
      4'hc: v = m_mask;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    string rtag;
    logic [31:0] er;
    if (!done && $time > 15) begin
      checks++;
      if (out_valid !== e_valid || out_hit !== e_hit || out_addr !== e_addr) begin
        errors++;
        $display("FAIL %s: out v/h/a = %0b/%0b/%08h expected %0b/%0b/%08h",
                 e_tag, out_valid, out_hit, out_addr, e_valid, e_hit, e_addr);
      end
      er = model_read(reg_addr);
      rtag = !rst_n ? "R1" : (reg_addr == 4'h0 || reg_addr == 4'h8 || reg_addr == 4'hc) ? "R2" : "R3";
      checks++;
      if (reg_rdata !== er) begin
        errors++;
        $display("FAIL %s: rdata[%0h] = %08h expected %08h", rtag, reg_addr, reg_rdata, er);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic req(input logic [31:0] a);
    host_valid = 1; host_addr = a;
    cyc();
    host_valid = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] sz, hb, lb;
    int k;
    cyc(); cyc(); cyc();
    rd(4'h0); rd(4'h8); rd(4'hc);          // R1 reset state
    rst_n = 1;
    cyc();
    rd(4'h0); rd(4'h8); rd(4'hc);          // R1 after release
    req(32'h0000_1234);                    // R4 disabled
    wr(4'h0, 32'h0000_0100); req(32'h0000_1234);   // R4 one enable
    wr(4'h0, 32'h0000_0400); req(32'h0000_1234);   // R4 other enable
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0);     // R2 only two bits kept
    req(32'h0000_1234);                    // R6 hit with zero mask
    req(32'h0001_0000);                    // R5 miss
    wr(4'h4, 32'hDEAD_BEEF); rd(4'h4); rd(4'h0); rd(4'h8); rd(4'hc); // R3
    wr(4'h8, 32'h8800_0030);
    wr(4'hc, 32'hFFF0_000F);               // 1 MiB window
    rd(4'h8); rd(4'hc);                    // R2
    req(32'h0034_5678);                    // R6 -> 8804_5678
    req(32'h0040_0000);                    // R5 just above
    req(32'h002F_FFFF);                    // R5 just below
    host_valid = 1; host_addr = 32'h0035_0001;     // R9 write same edge
    reg_wr = 1; reg_addr = 4'h8; reg_wdata = 32'h1200_0050;
    cyc();
    reg_wr = 0; host_addr = 32'h0055_0001; // R9 new contents
    cyc();
    host_valid = 0;
    cyc(); cyc();                          // R8 idle
    for (int it = 0; it < 4000; it++) begin
      if (it % 40 == 0) begin
        if ($urandom_range(0, 2) == 0) begin
          wr(4'h8, $urandom());
          wr(4'hc, $urandom());
        end else begin
          k = $urandom_range(16, 31);
          sz = 32'h1 << k;
          hb = $urandom() & ~(sz - 1);
          lb = $urandom() & ~(sz - 1);
          wr(4'h8, (lb & 32'hFFFF_0000) | (hb >> 16));
          wr(4'hc, ~(sz - 1) | ((sz >> 16) - 1));
        end
        wr(4'h0, ($urandom_range(0, 5) != 0) ? 32'h0000_0500 : {$urandom()} & 32'h0000_0500);
      end
      host_valid = $urandom_range(0, 3) != 0;
      host_addr = ($urandom_range(0, 1) != 0)
                  ? {m_remap[15:0] ^ (16'($urandom()) & m_mask[15:0]), 16'($urandom())}
                  : $urandom();
      if ($urandom_range(0, 15) == 0) begin
        reg_wr = 1;
        reg_addr = 4'($urandom_range(0, 3) * 4);
        reg_wdata = $urandom();
      end
      if (!reg_wr) reg_addr = 4'($urandom());
      cyc();
      reg_wr = 0;
    end
    host_valid = 0;
    cyc(); cyc();
    finish_run();
  end
endmodule